// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block keeps an extended-data-out DRAM array refreshed without supplying any row address. An interval timer produces one refresh credit every `INTERVAL_CYC` clock cycles. The default is 780 cycles at 50 MHz, which is about 15.6 µs. A pending counter holds these credits. While any credit is outstanding, the block raises a request to the access controller. When the pending counter fills, the block also raises an urgent flag.

Once the controller grants, the block runs one refresh command. First it pulls every column strobe low. Then it drops the row strobe. It releases the column strobes while the row strobe is still low. Finally it raises the row strobe and waits out the row precharge. The DRAM's internal row counter supplies the address, and write enable stays high for the whole time. A busy flag covers the command from the first strobe movement to the end of precharge. The controller is expected to hold its grant until busy falls.

All strobe timings are parameters counted in clock cycles. The defaults meet the mid speed grade at a 20 ns clock.

Top module: `cbr_refresh_seq`

## Requirements
- R1: Counting from reset release, the pending count rises by one on clock edge `INTERVAL_CYC` and on every `INTERVAL_CYC`-th edge after that.
- R2: `ref_req_o` is high exactly when the pending count is nonzero.
- R3: A refresh starts only when the sequencer is idle, `ref_gnt_i` is high and the pending count is nonzero. For `CSR_CYC` cycles all column strobes are low while the row strobe is high. Only after that does the row strobe fall.
- R4: The row strobe stays low for `RAS_CYC` cycles. The column strobes stay low for the first `CHR_CYC` of those cycles and are all high for the rest.
- R5: After the row strobe rises, it stays high for `RP_CYC` precharge cycles before `busy_o` falls. `busy_o` is high from the first cycle after the starting edge to the end of precharge. Whenever `busy_o` is low, every column strobe is high.
- R6: `we_n_o` is high at all times, including during reset and throughout each refresh.
- R7: Each completed refresh lowers the pending count by one. If a completion and an interval tick land on the same edge, the count is unchanged.
- R8: The pending count saturates at `PEND_MAX`, and further ticks leave it there. `ref_urgent_o` is high exactly when the count equals `PEND_MAX`.
- R9: A started refresh runs to completion even if `ref_gnt_i` falls during it. If the grant is still held and credits remain, the next refresh starts after exactly one idle cycle.
- R10: While `rst_ni` is low: the row strobe, all column strobes and write enable are high; `busy_o`, `ref_req_o` and `ref_urgent_o` are low; and the pending count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Grant from the access controller |
| ref_req_o | output | 1 | Refresh credits outstanding |
| ref_urgent_o | output | 1 | Pending counter saturated; must be served before new accesses |
| busy_o | output | 1 | Refresh command or precharge in progress |
| pend_cnt_o | output | $clog2(PEND_MAX+1) | Number of postponed refreshes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | CAS_W | Column strobes, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |

## Verification
The interval tick and the end of a refresh's precharge can land on the same clock edge. On that edge the pending counter sees an increment and a decrement together. The bench provokes this by granting a refresh exactly six cycles before a tick edge, which places the completion on that edge. It then checks that the count is unchanged. A second case lets ticks arrive at a saturated counter with no completion, and checks that the count holds at its maximum and that the urgent flag stays up.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CSR  = 2'd1,
    ST_ACT  = 2'd2,
    ST_PRE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + TW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          done_i,
  output logic [PW-1:0] cnt_o,
  output logic          req_o,
  output logic          urgent_o
);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({tick_i, done_i})
        2'b10:   if (cnt_q != FULL) cnt_q <= cnt_q + PW'(1);
        2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - PW'(1);
        default: cnt_q <= cnt_q;  // idle, or tick and completion cancel
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign req_o    = (cnt_q != '0);
  assign urgent_o = (cnt_q == FULL);
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
  import cbr_refresh_pkg::*;
#(
  parameter int CAS_W   = 8,
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int RP_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             gnt_i,
  output logic             done_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic [CAS_W-1:0] cas_n_o,
  output logic             we_n_o
);
  localparam int MAXA = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAXD = (MAXA > RP_CYC) ? MAXA : RP_CYC;
  localparam int SW   = $clog2(MAXD + 1);

  seq_state_e    state_q, state_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] dur;
  logic          last, cas_low;

  always_comb begin
    unique case (state_q)
      ST_CSR:  dur = SW'(CSR_CYC);
      ST_ACT:  dur = SW'(RAS_CYC);
      ST_PRE:  dur = SW'(RP_CYC);
      default: dur = SW'(1);
    endcase
  end

  assign last = (cnt_q == dur - SW'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + SW'(1);
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (gnt_i && req_i) state_d = ST_CSR;
      end
      ST_CSR: if (last) begin state_d = ST_ACT;  cnt_d = '0; end
      ST_ACT: if (last) begin state_d = ST_PRE;  cnt_d = '0; end
      ST_PRE: if (last) begin state_d = ST_IDLE; cnt_d = '0; end
      default: begin state_d = ST_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // column strobes lead the row strobe and release early in the active phase
  assign cas_low = (state_q == ST_CSR) ||
                   ((state_q == ST_ACT) && (cnt_q < SW'(CHR_CYC)));

  assign done_o  = (state_q == ST_PRE) && last;
  assign busy_o  = (state_q != ST_IDLE);
  assign ras_n_o = (state_q != ST_ACT);
  assign cas_n_o = {CAS_W{~cas_low}};
  assign we_n_o  = 1'b1;
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
  parameter int INTERVAL_CYC = 780,
  parameter int PEND_MAX     = 8,
  parameter int CAS_W        = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 3,
  parameter int RP_CYC       = 2,
  localparam int PW          = $clog2(PEND_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             ref_urgent_o,
  output logic             busy_o,
  output logic [PW-1:0]    pend_cnt_o,
  output logic             ras_n_o,
  output logic [CAS_W-1:0] cas_n_o,
  output logic             we_n_o
);
  logic tick, done;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  refresh_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .done_i   (done),
    .cnt_o    (pend_cnt_o),
    .req_o    (ref_req_o),
    .urgent_o (ref_urgent_o)
  );

  refresh_strobe_fsm #(
    .CAS_W   (CAS_W),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ref_req_o),
    .gnt_i   (ref_gnt_i),
    .done_o  (done),
    .busy_o  (busy_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o)
  );
endmodule

// File: rtl/cbr_refresh_seq_chk.sv
module cbr_refresh_seq_chk #(
  parameter int PEND_MAX = 8,
  parameter int CAS_W    = 8,
  localparam int PW      = $clog2(PEND_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_gnt_i,
  input logic             ref_req_o,
  input logic             ref_urgent_o,
  input logic             busy_o,
  input logic [PW-1:0]    pend_cnt_o,
  input logic             ras_n_o,
  input logic [CAS_W-1:0] cas_n_o,
  input logic             we_n_o
);
  // R3
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (cas_n_o == '0) && $past(cas_n_o == '0));

  // R3
  start_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ref_req_o) && $past(ref_gnt_i));

  // R5
  cas_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cas_n_o == '1) && ras_n_o);

  // R4
  ras_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> busy_o);

  // R6
  we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> we_n_o);

  // R7
  pend_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt_o == $past(pend_cnt_o)) ||
    (pend_cnt_o == $past(pend_cnt_o) + PW'(1)) ||
    (pend_cnt_o == $past(pend_cnt_o) - PW'(1)));

  // R8
  pend_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt_o <= PW'(PEND_MAX));

  // R8
  urgent_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o);
endmodule

bind cbr_refresh_seq cbr_refresh_seq_chk #(.PEND_MAX(PEND_MAX), .CAS_W(CAS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_gnt_i    (ref_gnt_i),
  .ref_req_o    (ref_req_o),
  .ref_urgent_o (ref_urgent_o),
  .busy_o       (busy_o),
  .pend_cnt_o   (pend_cnt_o),
  .ras_n_o      (ras_n_o),
  .cas_n_o      (cas_n_o),
  .we_n_o       (we_n_o)
);

// File: tb/cbr_refresh_seq_test.sv
module cbr_refresh_seq_test;
  localparam int INT  = 50;
  localparam int PMAX = 8;
  localparam int CW   = 8;
  localparam int PW   = $clog2(PMAX + 1);

  // per step after the starting edge: {busy, cas all low, ras_n}
  localparam logic [2:0] SEQ_TAB [7] = '{
    3'b111, 3'b110, 3'b100, 3'b100, 3'b101, 3'b101, 3'b001
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          gnt = 1'b0;
  logic          req, urgent, busy, ras_n, we_n;
  logic [PW-1:0] pend;
  logic [CW-1:0] cas_n;

  int n_chk = 0;
  int n_err = 0;
  int edge_n = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_ni) edge_n <= edge_n + 1;

  cbr_refresh_seq #(.INTERVAL_CYC(INT), .PEND_MAX(PMAX), .CAS_W(CW)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ref_gnt_i    (gnt),
    .ref_req_o    (req),
    .ref_urgent_o (urgent),
    .busy_o       (busy),
    .pend_cnt_o   (pend),
    .ras_n_o      (ras_n),
    .cas_n_o      (cas_n),
    .we_n_o       (we_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic to_edge(input int n);
    do @(negedge clk); while (edge_n < n);
  endtask

  task automatic walk(input int e0, input bit drop_gnt);
    for (int k = 0; k < 7; k++) begin
      to_edge(e0 + k);
      chk($sformatf("R5 busy step %0d", k), int'(busy), int'(SEQ_TAB[k][2]));
      chk($sformatf("R4 cas step %0d", k), int'(cas_n),
          SEQ_TAB[k][1] ? 0 : int'({CW{1'b1}}));
      chk($sformatf("R3 ras_n step %0d", k), int'(ras_n), int'(SEQ_TAB[k][0]));
      chk($sformatf("R6 we_n step %0d", k), int'(we_n), 1);
      if (drop_gnt && k == 0) gnt = 1'b0;  // R9 grant loss mid-command
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ras_n", int'(ras_n), 1);
    chk("R10 cas_n", int'(cas_n), int'({CW{1'b1}}));
    chk("R10 we_n", int'(we_n), 1);
    chk("R10 busy", int'(busy), 0);
    chk("R10 req", int'(req), 0);
    chk("R10 urgent", int'(urgent), 0);
    chk("R10 pend", int'(pend), 0);
    rst_ni = 1'b1;

    // R3 grant with no credit starts nothing
    to_edge(10); gnt = 1'b1;
    to_edge(13);
    chk("R3 no start without credit", int'(busy), 0);
    gnt = 1'b0;

    // R1 R2 first tick
    to_edge(INT - 1);
    chk("R1 pend before tick", int'(pend), 0);
    chk("R2 req before tick", int'(req), 0);
    to_edge(INT);
    chk("R1 pend after tick", int'(pend), 1);
    chk("R2 req after tick", int'(req), 1);

    // normal refresh, grant held through
    gnt = 1'b1;
    walk(INT + 1, 1'b0);
    gnt = 1'b0;
    chk("R7 pend after refresh", int'(pend), 0);
    chk("R2 req after refresh", int'(req), 0);

    // completion lands on tick edge 150; grant dropped after start
    to_edge(3 * INT - 7);
    chk("R1 pend second tick", int'(pend), 1);
    gnt = 1'b1;
    walk(3 * INT - 6, 1'b1);
    chk("R7 tick and completion same edge", int'(pend), 1);
    chk("R9 ran to end without grant", int'(busy), 0);

    // saturation
    to_edge(10 * INT - 1);
    chk("R8 pend below max", int'(pend), PMAX - 1);
    chk("R8 urgent below max", int'(urgent), 0);
    to_edge(10 * INT);
    chk("R8 pend at max", int'(pend), PMAX);
    chk("R8 urgent at max", int'(urgent), 1);
    to_edge(11 * INT);
    chk("R8 pend saturated", int'(pend), PMAX);
    chk("R8 urgent held", int'(urgent), 1);

    // back-to-back refreshes with grant held
    to_edge(11 * INT + 19);
    gnt = 1'b1;
    walk(11 * INT + 20, 1'b0);
    chk("R7 pend after urgent refresh", int'(pend), PMAX - 1);
    chk("R8 urgent cleared", int'(urgent), 0);
    to_edge(11 * INT + 27);
    chk("R9 restart busy", int'(busy), 1);
    chk("R9 restart cas", int'(cas_n), 0);
    chk("R9 restart ras_n", int'(ras_n), 1);
    gnt = 1'b0;
    to_edge(11 * INT + 33);
    chk("R9 second done busy", int'(busy), 0);
    chk("R7 second done pend", int'(pend), PMAX - 2);
    to_edge(12 * INT);
    chk("R1 tick after refreshes", int'(pend), PMAX - 1);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule